// File: doc/BRIEF.md
# Self-Testing SPI Master

This block is a single-slave SPI master that shifts bytes in both directions at once. A host pulses `start` with a mode code. In normal mode the block sends a three-byte frame made of a command byte, an address byte and a data byte. All 24 bits that the slave returns arrive on `rx_frame`. The slave-select line stays low for the whole frame.

In self-test mode the host bytes are not used. An 8-bit maximal-length LFSR generates `pat_count` transmit bytes, all sent in one frame with select held low. Each received byte is compared with the byte that went out, and every mismatch adds one to `err_count`. When the frame ends, `pass` reports whether no mismatch occurred. The received stream comes either from MOSI looped back inside the block or from the MISO pin, chosen by the mode code. A single trigger therefore exercises the shift path, and the pin variant also exercises the external wiring.

Top module: `spi_bist_master`

## Requirements
- R1: After reset `ss_n` is 1, `sclk` is 0, and `busy`, `done`, `pass` and `err_count` are 0. Whenever `busy` is 0, `ss_n` is 1.
- R2: `start` sampled at a rising clock edge while `busy` is 0 launches a frame. `ss_n` falls and `busy` rises at that same edge. The first rising `sclk` edge comes exactly SETTLE + DIV clock cycles later.
- R3: The bus runs in mode 0. `sclk` idles low, has a period of 2·DIV clock cycles, and stays low while `ss_n` is high. MOSI never changes while `sclk` is high. Bytes go out MSB first.
- R4: Mode code 2'b00 sends `ctrl_byte`, then `addr_byte`, then `data_byte`, giving exactly 24 rising `sclk` edges.
- R5: MISO is sampled on each rising `sclk` edge. In mode 2'b00, `rx_frame` holds the 24 received bits at the end of the frame, with the first bit in bit 23.
- R6: `ss_n` returns high DIV cycles after the last falling `sclk` edge. At the same edge `busy` falls and `done` is high for exactly one cycle. A frame of L bytes takes SETTLE + 16·DIV·L + DIV cycles from `ss_n` falling to `done`.
- R7: `start` and the host inputs are ignored while `busy` is 1. The running frame keeps its content and length, and no second frame follows it.
- R8: Mode codes 2'b01, 2'b10 and 2'b11 run a self-test of `pat_count` bytes in one frame. Byte 0 is 8'h01. Each later byte is the previous byte s advanced to {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R9: Mode codes 2'b01 and 2'b11 loop MOSI back as the received data and ignore the MISO pin. A test then ends with `err_count` 0 and `pass` 1.
- R10: Mode code 2'b10 compares MISO-pin bytes against the sent bytes. `err_count` equals the number of differing bytes, and `pass` is 1 only if that number is 0. Both are cleared when a self-test starts and are held through later normal frames.
- R11: A self-test started with `pat_count` 0 never lowers `ss_n` or raises `busy`. It pulses `done` at the accepting edge with `pass` 1 and `err_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Frame or test request, taken only when idle |
| mode | input | 2 | 00 normal, 01/11 self-test with internal loopback, 10 self-test through MISO pin |
| ctrl_byte | input | 8 | First byte of a normal frame |
| addr_byte | input | 8 | Second byte of a normal frame |
| data_byte | input | 8 | Third byte of a normal frame |
| pat_count | input | CNT_W | Number of patterns in a self-test |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame or test completion |
| rx_frame | output | 24 | Last 24 bits received, newest in bit 0 |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| pass | output | 1 | Last self-test had no mismatch |
| err_count | output | CNT_W | Mismatched bytes in the last self-test |

## Verification
Every result is due at a fixed cycle that follows from the two parameters. Select and busy change at the edge that takes the request. The first serial clock rise comes SETTLE + DIV cycles later, and done comes SETTLE + 16·DIV·L + DIV cycles after select falls. The bench counts clock edges from the observed fall of select and samples outputs on the falling system clock edge. It then compares the measured cycle numbers with these formulas. Frame content, the LFSR sequence, the error count and the received word are checked right after done, when they are final. The expected error count comes from a bench-side model of the pattern sequence run against a MISO pin held at a constant value.

// File: rtl/spi_bist_pkg.sv
package spi_bist_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int RX_W        = BYTE_W * FRAME_BYTES;
  localparam logic [BYTE_W-1:0] PRBS_SEED = 8'h01;
  // taps for x^8+x^6+x^5+x^4+1, left-shifting Fibonacci form
  localparam logic [BYTE_W-1:0] PRBS_TAPS = 8'b1011_1000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SHIFT,
    ST_TAIL
  } xfer_st_t;
endpackage

// File: rtl/spi_bist_lfsr.sv
module spi_bist_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] state_d;

  assign nxt = {cur[W-2:0], ^(cur & TAPS)};

  always_comb begin
    state_d = cur;
    if (load)      state_d = SEED;
    else if (step) state_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= SEED;
    else        cur <= state_d;
  end
endmodule

// File: rtl/spi_bist_cmp.sv
module spi_bist_cmp #(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          check,
  input  logic [W-1:0]  sent,
  input  logic [W-1:0]  got,
  output logic [CW-1:0] errs
);
  logic [CW-1:0] errs_d;

  always_comb begin
    errs_d = errs;
    if (clr)                        errs_d = '0;
    else if (check && (sent != got)) errs_d = errs + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errs <= '0;
    else        errs <= errs_d;
  end
endmodule

// File: rtl/spi_bist_master.sv
module spi_bist_master
  import spi_bist_pkg::*;
#(
  parameter int DIV    = 2,
  parameter int SETTLE = 3,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [7:0]       ctrl_byte,
  input  logic [7:0]       addr_byte,
  input  logic [7:0]       data_byte,
  input  logic [CNT_W-1:0] pat_count,
  output logic             busy,
  output logic             done,
  output logic [23:0]      rx_frame,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n,
  output logic             pass,
  output logic [CNT_W-1:0] err_count
);
  localparam int CMAX = (DIV > SETTLE) ? DIV : SETTLE;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HALF_LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  xfer_st_t          st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [CNT_W-1:0]  byte_q, byte_d, last_q, last_d;
  logic [1:0]        mode_q, mode_d;
  logic              sclk_q, sclk_d, ss_q, ss_d, busy_q, busy_d;
  logic              done_q, done_d, pass_q, pass_d;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_d, tx_byte_q, tx_byte_d, addr_q, addr_d, data_q, data_d;
  logic [RX_W-1:0]   rx_q, rx_d;

  logic              test_q, test_req, accept, half_end, rise, fall, byte_end, frame_end, miso_in;
  logic [BYTE_W-1:0] next_byte, prbs_cur, prbs_nxt;

  assign test_q    = |mode_q;
  assign test_req  = |mode;
  assign accept    = (st_q == ST_IDLE) && start;
  assign half_end  = (cnt_q == HALF_LAST);
  assign rise      = (st_q == ST_SHIFT) && half_end && !sclk_q;
  assign fall      = (st_q == ST_SHIFT) && half_end && sclk_q;
  assign byte_end  = fall && (bit_q == 3'd7);
  assign frame_end = byte_end && (byte_q == last_q);
  assign miso_in   = mode_q[0] ? tx_sh_q[BYTE_W-1] : miso;

  always_comb begin
    if (test_q)                  next_byte = prbs_nxt;
    else if (byte_q == '0)       next_byte = addr_q;
    else                         next_byte = data_q;
  end

  spi_bist_lfsr #(.W(BYTE_W), .SEED(PRBS_SEED), .TAPS(PRBS_TAPS)) u_prbs (
    .clk  (clk),
    .rst_n(rst_ni),
    .load (accept && test_req),
    .step (byte_end && !frame_end && test_q),
    .cur  (prbs_cur),
    .nxt  (prbs_nxt)
  );

  spi_bist_cmp #(.W(BYTE_W), .CW(CNT_W)) u_cmp (
    .clk  (clk),
    .rst_n(rst_ni),
    .clr  (accept && test_req),
    .check(rise && (bit_q == 3'd7) && test_q),
    .sent (tx_byte_q),
    .got  ({rx_q[BYTE_W-2:0], miso_in}),
    .errs (err_count)
  );

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  bit_d = bit_q;  byte_d = byte_q;  last_d = last_q;
    mode_d = mode_q;  sclk_d = sclk_q;  ss_d = ss_q;  busy_d = busy_q;
    done_d = 1'b0;  pass_d = pass_q;  tx_sh_d = tx_sh_q;  tx_byte_d = tx_byte_q;
    addr_d = addr_q;  data_d = data_q;  rx_d = rx_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (test_req && (pat_count == '0)) begin
          done_d = 1'b1;
          pass_d = 1'b1;
        end else begin
          st_d      = ST_SETTLE;
          cnt_d     = '0;
          ss_d      = 1'b0;
          busy_d    = 1'b1;
          mode_d    = mode;
          bit_d     = '0;
          byte_d    = '0;
          last_d    = test_req ? pat_count - CNT_W'(1) : CNT_W'(FRAME_BYTES - 1);
          tx_sh_d   = test_req ? prbs_cur_seed() : ctrl_byte;
          tx_byte_d = tx_sh_d;
          addr_d    = addr_byte;
          data_d    = data_byte;
          if (test_req) pass_d = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          st_d  = ST_SHIFT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_SHIFT: begin
        if (half_end) begin
          cnt_d  = '0;
          sclk_d = !sclk_q;
          if (rise) rx_d = {rx_q[RX_W-2:0], miso_in};
          if (fall) begin
            if (bit_q == 3'd7) begin
              bit_d = '0;
              if (frame_end) begin
                st_d = ST_TAIL;
              end else begin
                byte_d    = byte_q + CNT_W'(1);
                tx_sh_d   = next_byte;
                tx_byte_d = next_byte;
              end
            end else begin
              bit_d   = bit_q + 3'd1;
              tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_TAIL: begin
        if (half_end) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          ss_d   = 1'b1;
          busy_d = 1'b0;
          done_d = 1'b1;
          if (test_q) pass_d = (err_count == '0);
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  function automatic logic [BYTE_W-1:0] prbs_cur_seed();
    return PRBS_SEED;
  endfunction

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  bit_q <= '0;  byte_q <= '0;  last_q <= '0;
      mode_q <= '0;  sclk_q <= 1'b0;  ss_q <= 1'b1;  busy_q <= 1'b0;
      done_q <= 1'b0;  pass_q <= 1'b0;  tx_sh_q <= '0;  tx_byte_q <= '0;
      addr_q <= '0;  data_q <= '0;  rx_q <= '0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  bit_q <= bit_d;  byte_q <= byte_d;  last_q <= last_d;
      mode_q <= mode_d;  sclk_q <= sclk_d;  ss_q <= ss_d;  busy_q <= busy_d;
      done_q <= done_d;  pass_q <= pass_d;  tx_sh_q <= tx_sh_d;  tx_byte_q <= tx_byte_d;
      addr_q <= addr_d;  data_q <= data_d;  rx_q <= rx_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rx_frame = rx_q;
  assign sclk     = sclk_q;
  assign mosi     = tx_sh_q[BYTE_W-1];
  assign ss_n     = ss_q;
  assign pass     = pass_q;
endmodule

// File: rtl/spi_bist_master_chk.sv
module spi_bist_master_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             mosi,
  input logic             ss_n,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] err_count
);
  // R1: select is released whenever no frame runs
  p_idle_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss_n);

  // R3: serial clock rests low while unselected
  p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);

  // R3: data line holds while serial clock is high
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R2: select only drops when a frame is launched
  p_select_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> busy);

  // R6: release of select coincides with done and idle
  p_release_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (done && !busy));

  // R10: error count never falls during a running test
  p_err_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (err_count >= $past(err_count)));
endmodule

bind spi_bist_master spi_bist_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .ss_n     (ss_n),
  .busy     (busy),
  .done     (done),
  .err_count(err_count)
);

// File: tb/spi_bist_master_bench.sv
`timescale 1ns/1ps
module spi_bist_master_bench;
  localparam int DIV = 2;
  localparam int SET = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mode;
  logic [7:0] ctrl_byte, addr_byte, data_byte, pat_count;
  logic busy, done, sclk, mosi, miso, ss_n, pass;
  logic [23:0] rx_frame;
  logic [7:0] err_count;

  always #4 clk = ~clk;

  spi_bist_master #(.DIV(DIV), .SETTLE(SET), .CNT_W(8)) u_spi_bist_master (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .ctrl_byte(ctrl_byte), .addr_byte(addr_byte), .data_byte(data_byte),
    .pat_count(pat_count), .busy(busy), .done(done), .rx_frame(rx_frame),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .pass(pass),
    .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // slave model and MISO source: 0 slave reply, 1 constant low, 2 constant high
  int miso_sel = 0;
  logic [23:0] reply = '0;
  logic [23:0] reply_sh = '0;
  assign miso = (miso_sel == 0) ? reply_sh[23] : (miso_sel == 2);

  int edge_cnt = 0;
  logic [7:0] cap_sh = '0;
  logic [7:0] cap_arr [0:255];

  always @(negedge ss_n) begin
    edge_cnt = 0;
    reply_sh = reply;
  end
  always @(negedge sclk) reply_sh = {reply_sh[22:0], 1'b0};
  always @(posedge sclk) begin
    cap_sh = {cap_sh[6:0], mosi};
    if ((edge_cnt % 8 == 7) && (edge_cnt / 8 < 256)) cap_arr[edge_cnt / 8] = cap_sh;
    edge_cnt++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] prbs_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // launch one frame, check its timing (R2, R6) and optionally poke start mid-frame (R7)
  task automatic run_frame(input logic [1:0] md, input logic [7:0] c, input logic [7:0] a,
                           input logic [7:0] d, input int pat, input bit poke);
    int len;
    longint t0, trise, tdone;
    len = (md == 2'b00) ? 3 : pat;
    @(negedge clk);
    mode = md; ctrl_byte = c; addr_byte = a; data_byte = d; pat_count = pat[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    chk("R2", "ss_n after accept", ss_n, 0);
    chk("R2", "busy after accept", busy, 1);
    trise = -1;
    tdone = -1;
    for (int n = 0; n < 20000 && tdone < 0; n++) begin
      @(negedge clk);
      if (poke && cyc == t0 + 20) begin
        start = 1'b1; mode = 2'b01; pat_count = 8'd9;
        ctrl_byte = ~c; addr_byte = ~a; data_byte = ~d;
      end else begin
        start = 1'b0;
      end
      if (sclk && trise < 0) trise = cyc;
      if (done) begin
        tdone = cyc;
        chk("R6", "ss_n at done", ss_n, 1);
        chk("R6", "busy at done", busy, 0);
      end
    end
    if (tdone < 0) begin
      checks++; errors++;
      $display("FAIL R6 frame never completed: actual none expected done");
      finish_run();
    end
    chk("R2", "settle to first sclk rise", trise - t0, SET + DIV);
    chk("R6", "frame duration", tdone - t0, SET + 16 * DIV * len + DIV);
    chk("R4", "sclk rising edges", edge_cnt, 8 * len);
    @(negedge clk);
    chk("R6", "done is one cycle", done, 0);
  endtask

  // self-test run against a pin value and expected outcome (R8, R9, R10)
  task automatic run_test(input logic [1:0] md, input int pat, input int pin);
    logic [7:0] p;
    int bad, experr;
    miso_sel = pin;
    run_frame(md, 8'h00, 8'h00, 8'h00, pat, 1'b0);
    p = 8'h01; bad = 0; experr = 0;
    for (int i = 0; i < pat; i++) begin
      if (cap_arr[i] !== p) bad++;
      if (md == 2'b10 && p != ((pin == 2) ? 8'hFF : 8'h00)) experr++;
      p = prbs_step(p);
    end
    chk("R8", "pattern bytes off sequence", bad, 0);
    if (md == 2'b10) begin
      chk("R10", "pin error count", err_count, experr);
      chk("R10", "pin pass flag", pass, (experr == 0) ? 1 : 0);
    end else begin
      chk("R9", "loopback error count", err_count, 0);
      chk("R9", "loopback pass flag", pass, 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'b00;
    ctrl_byte = '0; addr_byte = '0; data_byte = '0; pat_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ss_n reset", ss_n, 1);
    chk("R1", "sclk reset", sclk, 0);
    chk("R1", "busy reset", busy, 0);
    chk("R1", "done reset", done, 0);
    chk("R1", "pass reset", pass, 0);
    chk("R1", "err reset", err_count, 0);

    // normal frames: R3 R4 R5
    miso_sel = 0;
    reply = 24'h5A3C81;
    run_frame(2'b00, 8'h14, 8'h00, 8'hAA, 0, 1'b0);
    chk("R4", "frame bytes MSB first", {cap_arr[0], cap_arr[1], cap_arr[2]}, 24'h1400AA);
    chk("R5", "received frame", rx_frame, 24'h5A3C81);

    // start during a frame: R7
    reply = 24'h00FF7E;
    run_frame(2'b00, 8'hFF, 8'h01, 8'h80, 0, 1'b1);
    chk("R7", "frame kept under poke", {cap_arr[0], cap_arr[1], cap_arr[2]}, 24'hFF0180);
    chk("R5", "received frame 2", rx_frame, 24'h00FF7E);
    repeat (10) @(negedge clk);
    chk("R7", "no queued frame", ss_n, 1);
    chk("R7", "no test ran", pass, 0);

    // loopback self-tests with pin forced opposite: R8 R9
    run_test(2'b01, 1, 2);
    run_test(2'b01, 2, 1);
    run_test(2'b11, 7, 2);
    run_test(2'b01, 255, 1);

    // pin self-tests: R10
    run_test(2'b10, 5, 1);
    run_test(2'b10, 255, 2);

    // hold through normal frame: R10
    reply = 24'hC3C3C3;
    miso_sel = 0;
    run_frame(2'b00, 8'h81, 8'h42, 8'h24, 0, 1'b0);
    chk("R10", "err held over normal frame", err_count, 254);
    chk("R10", "pass held over normal frame", pass, 0);

    // zero-length test: R11
    @(negedge clk);
    mode = 2'b01; pat_count = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "done at accept", done, 1);
    chk("R11", "ss_n stays high", ss_n, 1);
    chk("R11", "busy stays low", busy, 0);
    chk("R11", "pass set", pass, 1);
    chk("R11", "err cleared", err_count, 0);
    @(negedge clk);
    chk("R11", "done pulse ends", done, 0);
    chk("R11", "ss_n still high", ss_n, 1);

    finish_run();
  end
endmodule